// File: doc/BRIEF.md
# High-Speed IN Data Babble and Handshake Checker

This block watches the data phase of one high-speed IN transaction at a time. When the receive path announces a new data packet, it latches the packet's byte budget, which is the smaller of the bytes the transfer still expects and the endpoint's maximum packet size. It also compares the received data PID with the toggle the host expects. It then counts the incoming bytes. Any byte beyond the budget is a packet babble. If the packet is still running at the micro-frame EOF2 point, that is a frame babble, and the block asks for the port to be disabled.

At end of packet the block decides whether the host returns an ACK or stays silent. It also decides whether the descriptor's error counter is decremented, and whether the payload must be thrown away. Sticky status flags record babble, frame babble and data buffer error until the descriptor write-back logic clears them with a write-one-to-clear pulse. A one-cycle error event goes to the interrupt logic.

Received bytes arrive on a valid/ready stream. Ready is high exactly while a packet is open. The checker never stalls a byte inside a packet, so the upstream receiver may treat ready as an "accepting" indication rather than as back-pressure. A byte offered while ready is low is dropped and has no effect. All outputs except ready are registered and change on the clock edge that follows the input cycle that caused them.

Top module: `in_babble_chk`

## Requirements
- R1: Out of reset every flag, pulse and handshake output is 0 and rx_ready is 0.
- R2: With matching toggle the byte budget is min(remain_bytes, max_pkt); a byte accepted when the count already equals the budget sets babble_flag on the next edge.
- R3: A packet carrying exactly its budget of bytes raises no babble_flag.
- R4: On a toggle mismatch (rx_pid_odd, 1 = DATA1, differs from exp_odd) the budget is max_pkt alone; a clean end of packet then gives hs_valid with hs_ack=1 and data_discard=1.
- R5: A packet that babbled ends with hs_valid=1, hs_ack=0 and no cerr_dec.
- R6: eof2 while a packet is open sets frame_babble_flag, pulses port_disable for one cycle, closes the packet and produces no handshake.
- R7: buf_overrun on a data cycle of an open packet sets dbe_flag; that packet ends with hs_ack=0 and no cerr_dec.
- R8: rx_eop with pkt_bad=1 and no babble or overrun gives cerr_dec=1 together with hs_valid=1, hs_ack=0.
- R9: A clean, toggle-matching packet within budget ends with hs_valid=1, hs_ack=1, data_discard=0.
- R10: The byte counter saturates at 2^(MPS_W+1)-1 (4095 by default) and never wraps, so every later byte stays over budget.
- R11: flag_clr bit 0 clears babble_flag, bit 1 frame_babble_flag, bit 2 dbe_flag; a set in the same cycle wins over the clear.
- R12: usb_err_evt pulses for the first over-budget byte of a packet and for every frame babble, and at no other time.
- R13: rx_ready equals "packet open"; bytes offered when it is low, or in the rx_eop, eof2 or pkt_start cycle, are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Opens a data packet; latches budget and toggle check |
| remain_bytes | input | LEN_W | Bytes still expected by the transfer |
| max_pkt | input | MPS_W | Endpoint maximum packet size |
| exp_odd | input | 1 | Expected toggle, 1 = DATA1 |
| rx_pid_odd | input | 1 | Received data PID, 1 = DATA1 |
| rx_valid | input | 1 | A received byte is offered |
| rx_ready | output | 1 | High while a packet is open |
| rx_eop | input | 1 | End of packet (carries no byte) |
| pkt_bad | input | 1 | Packet failed integrity check, valid with rx_eop |
| buf_overrun | input | 1 | Memory side could not absorb data |
| eof2 | input | 1 | Micro-frame EOF2 timing pulse |
| flag_clr | input | 3 | Write-one-to-clear for the three flags |
| babble_flag | output | 1 | Sticky packet babble |
| frame_babble_flag | output | 1 | Sticky frame babble |
| dbe_flag | output | 1 | Sticky data buffer error |
| port_disable | output | 1 | One-cycle request to disable the port |
| cerr_dec | output | 1 | One-cycle error counter decrement enable |
| hs_valid | output | 1 | Handshake decision is present |
| hs_ack | output | 1 | 1 = send ACK, 0 = send nothing |
| data_discard | output | 1 | Payload must be dropped (toggle mismatch) |
| usb_err_evt | output | 1 | One-cycle error event for interrupt logic |

## Verification
The bench aims at the budget edge: exactly min(remain, max) bytes must pass, and one more must trip. A design that compared with the wrong operator, or took the larger of the two limits, would flag good packets or let babble through. Toggle-mismatch packets that carry more bytes than the remaining count but fit the packet size would be wrongly flagged by a design that kept the transfer limit. The same packets expose a missing discard or a missing ACK. A run of over four thousand bytes followed by a flag clear checks that the counter does not wrap back below the budget. The bench also covers frame babble at EOF2, overrun and CRC-failed endings, and set-versus-clear collisions. These show up a design that decremented the error count for babble or overrun, or that acknowledged an overrun packet.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
  typedef enum logic {
    HS_NONE = 1'b0,
    HS_ACK  = 1'b1
  } hs_sel_e;

  typedef struct packed {
    logic buf_err;
    logic frame_babble;
    logic babble;
  } flag_set_t;
endpackage

// File: rtl/ibc_limit.sv
module ibc_limit #(
  parameter int LEN_W       = 15,
  parameter int MPS_W       = 11,
  parameter bit MIS_USE_MPS = 1'b1
) (
  input  logic [LEN_W-1:0] remain_bytes,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             mismatch,
  output logic [MPS_W-1:0] limit,
  output logic             chk_en
);
  localparam int PAD_W = LEN_W - MPS_W;

  logic [LEN_W-1:0] mps_ext;
  logic [MPS_W-1:0] xfer_lim;

  assign mps_ext = {{PAD_W{1'b0}}, max_pkt};

  always_comb begin
    if (remain_bytes < mps_ext) xfer_lim = remain_bytes[MPS_W-1:0];
    else                        xfer_lim = max_pkt;
  end

  generate
    if (MIS_USE_MPS) begin : g_fallback
      always_comb begin
        limit  = mismatch ? max_pkt : xfer_lim;
        chk_en = 1'b1;
      end
    end else begin : g_suspend
      always_comb begin
        limit  = xfer_lim;
        chk_en = !mismatch;
      end
    end
  endgenerate
endmodule

// File: rtl/ibc_counter.sv
module ibc_counter #(
  parameter int MPS_W = 11,
  parameter int CNT_W = MPS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             chk_en,
  input  logic [MPS_W-1:0] limit,
  output logic             over
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
  localparam int PAD_W = CNT_W - MPS_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_ext;

  assign lim_ext = {{PAD_W{1'b0}}, limit};
  assign over    = inc && chk_en && (cnt >= lim_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (inc && cnt != SAT) cnt <= cnt + 1'b1;
  end

  // R10
  cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SAT && !clr) |=> (cnt == SAT));

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt != SAT) |=> (cnt == $past(cnt) + 1'b1));

  // R13
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/ibc_status.sv
module ibc_status
  import ibc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_set_t set,
  input  logic [2:0] clr,
  output flag_set_t q
);
  flag_set_t nxt;

  always_comb begin
    nxt.babble       = set.babble       | (q.babble       & !clr[0]);
    nxt.frame_babble = set.frame_babble | (q.frame_babble & !clr[1]);
    nxt.buf_err      = set.buf_err      | (q.buf_err      & !clr[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set.babble |=> q.babble);

  // R11
  fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q.frame_babble && !clr[1]) |=> q.frame_babble);

  // R11
  dbe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[2] && !set.buf_err) |=> !q.buf_err);
endmodule

// File: rtl/in_babble_chk.sv
module in_babble_chk
  import ibc_pkg::*;
#(
  parameter int LEN_W       = 15,
  parameter int MPS_W       = 11,
  parameter bit MIS_USE_MPS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic [LEN_W-1:0] remain_bytes,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             exp_odd,
  input  logic             rx_pid_odd,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic             rx_eop,
  input  logic             pkt_bad,
  input  logic             buf_overrun,
  input  logic             eof2,
  input  logic [2:0]       flag_clr,
  output logic             babble_flag,
  output logic             frame_babble_flag,
  output logic             dbe_flag,
  output logic             port_disable,
  output logic             cerr_dec,
  output logic             hs_valid,
  output logic             hs_ack,
  output logic             data_discard,
  output logic             usb_err_evt
);
  localparam int CNT_W = MPS_W + 1;

  logic             open_q;
  logic             mis_q, chk_q, bab_seen_q, ovr_seen_q;
  logic [MPS_W-1:0] lim_q;
  logic [MPS_W-1:0] lim_d;
  logic             chk_d, mismatch;
  logic             data_cyc, byte_acc, fb_hit, eop_hit, ovr_hit, over;
  hs_sel_e          hs_sel;
  flag_set_t        fset, fq;

  assign mismatch = (rx_pid_odd != exp_odd);

  ibc_limit #(.LEN_W(LEN_W), .MPS_W(MPS_W), .MIS_USE_MPS(MIS_USE_MPS)) u_limit (
    .remain_bytes(remain_bytes), .max_pkt(max_pkt), .mismatch(mismatch),
    .limit(lim_d), .chk_en(chk_d)
  );

  assign rx_ready = open_q;
  assign data_cyc = open_q && !pkt_start && !eof2 && !rx_eop;
  assign byte_acc = data_cyc && rx_valid;
  assign fb_hit   = open_q && !pkt_start && eof2;
  assign eop_hit  = open_q && !pkt_start && !eof2 && rx_eop;
  assign ovr_hit  = data_cyc && buf_overrun;

  ibc_counter #(.MPS_W(MPS_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(pkt_start), .inc(byte_acc),
    .chk_en(chk_q), .limit(lim_q), .over(over)
  );

  always_comb begin
    fset.babble       = over;
    fset.frame_babble = fb_hit;
    fset.buf_err      = ovr_hit;
  end

  ibc_status u_stat (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(flag_clr), .q(fq)
  );

  assign babble_flag       = fq.babble;
  assign frame_babble_flag = fq.frame_babble;
  assign dbe_flag          = fq.buf_err;

  always_comb begin
    if (bab_seen_q || ovr_seen_q || pkt_bad) hs_sel = HS_NONE;
    else                                     hs_sel = HS_ACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      mis_q      <= 1'b0;
      chk_q      <= 1'b0;
      bab_seen_q <= 1'b0;
      ovr_seen_q <= 1'b0;
      lim_q      <= '0;
    end else if (pkt_start) begin
      open_q     <= 1'b1;
      mis_q      <= mismatch;
      chk_q      <= chk_d;
      bab_seen_q <= 1'b0;
      ovr_seen_q <= 1'b0;
      lim_q      <= lim_d;
    end else begin
      if (fb_hit || eop_hit) open_q <= 1'b0;
      if (over)              bab_seen_q <= 1'b1;
      if (ovr_hit)           ovr_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_disable <= 1'b0;
      usb_err_evt  <= 1'b0;
      hs_valid     <= 1'b0;
      hs_ack       <= 1'b0;
      data_discard <= 1'b0;
      cerr_dec     <= 1'b0;
    end else begin
      port_disable <= fb_hit;
      usb_err_evt  <= fb_hit || (over && !bab_seen_q);
      hs_valid     <= eop_hit;
      hs_ack       <= eop_hit && (hs_sel == HS_ACK);
      data_discard <= eop_hit && (hs_sel == HS_ACK) && mis_q;
      cerr_dec     <= eop_hit && pkt_bad && !bab_seen_q && !ovr_seen_q;
    end
  end

  // R6
  pd_with_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_disable |-> frame_babble_flag);

  // R12
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_err_evt |-> (babble_flag || frame_babble_flag));

  // R6
  hs_vs_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_valid, port_disable}));

  // R8
  cerr_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cerr_dec |-> (hs_valid && !hs_ack));

  // R4
  discard_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_discard |-> (hs_valid && hs_ack));

  // R13
  closed_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid || port_disable) |-> !rx_ready || $past(pkt_start));
endmodule

// File: tb/in_babble_chk_tb_top.sv
module in_babble_chk_tb_top;
  localparam int LEN_W = 15;
  localparam int MPS_W = 11;
  localparam int SAT   = (1 << (MPS_W + 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 0, exp_odd = 0, rx_pid_odd = 0, rx_valid = 0;
  logic rx_eop = 0, pkt_bad = 0, buf_overrun = 0, eof2 = 0;
  logic [LEN_W-1:0] remain_bytes = '0;
  logic [MPS_W-1:0] max_pkt = '0;
  logic [2:0] flag_clr = '0;
  logic rx_ready, babble_flag, frame_babble_flag, dbe_flag, port_disable;
  logic cerr_dec, hs_valid, hs_ack, data_discard, usb_err_evt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  in_babble_chk #(.LEN_W(LEN_W), .MPS_W(MPS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .remain_bytes(remain_bytes),
    .max_pkt(max_pkt), .exp_odd(exp_odd), .rx_pid_odd(rx_pid_odd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_eop(rx_eop), .pkt_bad(pkt_bad),
    .buf_overrun(buf_overrun), .eof2(eof2), .flag_clr(flag_clr),
    .babble_flag(babble_flag), .frame_babble_flag(frame_babble_flag),
    .dbe_flag(dbe_flag), .port_disable(port_disable), .cerr_dec(cerr_dec),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .data_discard(data_discard),
    .usb_err_evt(usb_err_evt)
  );

  // behavioural reference
  bit m_open, m_mis, m_bseen, m_oseen;
  int m_cnt, m_lim;
  bit e_bab, e_fb, e_dbe, e_pd, e_cerr, e_hsv, e_ack, e_disc, e_evt;

  always @(posedge clk) begin
    bit over, fb, eop, dcyc, ovr;
    if (!rst_n) begin
      m_open = 0; m_mis = 0; m_bseen = 0; m_oseen = 0; m_cnt = 0; m_lim = 0;
      {e_bab, e_fb, e_dbe, e_pd, e_cerr, e_hsv, e_ack, e_disc, e_evt} = '0;
    end else begin
      over = 0; fb = 0; eop = 0; ovr = 0;
      dcyc = m_open && !pkt_start && !eof2 && !rx_eop;
      if (pkt_start) begin
        m_mis = (rx_pid_odd != exp_odd);
        m_lim = m_mis ? int'(max_pkt)
              : ((int'(remain_bytes) < int'(max_pkt)) ? int'(remain_bytes) : int'(max_pkt));
      end else if (m_open && eof2) fb = 1;
      else if (m_open && rx_eop) eop = 1;
      if (dcyc && rx_valid) begin
        over = (m_cnt >= m_lim);
        if (m_cnt < SAT) m_cnt++;
      end
      ovr = dcyc && buf_overrun;
      e_pd   = fb;
      e_evt  = fb || (over && !m_bseen);
      e_hsv  = eop;
      e_ack  = eop && !(m_bseen || m_oseen || pkt_bad);
      e_disc = e_ack && m_mis;
      e_cerr = eop && pkt_bad && !m_bseen && !m_oseen;
      e_bab  = over || (e_bab && !flag_clr[0]);
      e_fb   = fb   || (e_fb  && !flag_clr[1]);
      e_dbe  = ovr  || (e_dbe && !flag_clr[2]);
      if (pkt_start) begin m_open = 1; m_cnt = 0; m_bseen = 0; m_oseen = 0; end
      else begin
        if (fb || eop) m_open = 0;
        if (over) m_bseen = 1;
        if (ovr)  m_oseen = 1;
      end
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2 babble_flag", babble_flag, e_bab);
    chk("R6 frame_babble_flag", frame_babble_flag, e_fb);
    chk("R7 dbe_flag", dbe_flag, e_dbe);
    chk("R6 port_disable", port_disable, e_pd);
    chk("R8 cerr_dec", cerr_dec, e_cerr);
    chk("R9 hs_valid", hs_valid, e_hsv);
    chk("R5 hs_ack", hs_ack, e_ack);
    chk("R4 data_discard", data_discard, e_disc);
    chk("R12 usb_err_evt", usb_err_evt, e_evt);
    chk("R13 rx_ready", rx_ready, m_open);
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic start(int rem, int mps, bit ex, bit pid);
    pkt_start = 1; remain_bytes = LEN_W'(rem); max_pkt = MPS_W'(mps);
    exp_odd = ex; rx_pid_odd = pid;
    cyc(); pkt_start = 0;
  endtask

  task automatic bytes(int n, int ovr_at = -1);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; buf_overrun = (i == ovr_at);
      cyc();
    end
    rx_valid = 0; buf_overrun = 0;
  endtask

  task automatic end_pkt(bit bad);
    rx_eop = 1; pkt_bad = bad; cyc(); rx_eop = 0; pkt_bad = 0;
  endtask

  task automatic clr(logic [2:0] m); flag_clr = m; cyc(); flag_clr = 0; endtask

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 hs_valid", hs_valid, 0);
    chk("R1 babble_flag", babble_flag, 0);
    rst_n = 1; cyc();
    // R13: bytes while idle are ignored
    bytes(3); chk("R13 idle bytes", babble_flag, 0);
    // R9/R3: exactly min(100,64)=64 bytes, clean
    start(100, 64, 0, 0); bytes(64); end_pkt(0);
    chk("R9 hs_ack", hs_ack, 1); chk("R3 no babble", babble_flag, 0);
    // R2/R5/R12: limit min(10,64)=10, send 11
    start(10, 64, 1, 1); bytes(11); bytes(2); end_pkt(0);
    chk("R5 no ack", hs_ack, 0); chk("R5 no cerr", cerr_dec, 0);
    chk("R2 babble set", babble_flag, 1);
    clr(3'b001); chk("R11 cleared", babble_flag, 0);
    // R4: mismatch, remain 10 but mps 16 -> 16 bytes ok
    start(10, 16, 0, 1); bytes(16); end_pkt(0);
    chk("R4 ack", hs_ack, 1); chk("R4 discard", data_discard, 1);
    chk("R4 no babble", babble_flag, 0);
    start(10, 16, 1, 0); bytes(17); end_pkt(0);
    chk("R4 babble over mps", babble_flag, 1);
    clr(3'b001);
    // R7: overrun
    start(50, 64, 0, 0); bytes(5, 2); end_pkt(0);
    chk("R7 no ack", hs_ack, 0); chk("R7 no cerr", cerr_dec, 0);
    chk("R7 dbe", dbe_flag, 1);
    clr(3'b100);
    // R8: bad packet
    start(50, 64, 0, 0); bytes(5); end_pkt(1);
    chk("R8 cerr", cerr_dec, 1); chk("R8 no ack", hs_ack, 0);
    // R6: frame babble
    start(50, 64, 0, 0); bytes(4); eof2 = 1; cyc(); eof2 = 0;
    chk("R6 port_disable", port_disable, 1); chk("R6 open closed", rx_ready, 0);
    cyc(); end_pkt(0); chk("R6 no hs after eof2", hs_valid, 0);
    // R11: set wins over clear
    clr(3'b010); chk("R11 fb cleared", frame_babble_flag, 0);
    start(2, 64, 0, 0); bytes(2);
    rx_valid = 1; flag_clr = 3'b001; cyc(); rx_valid = 0; flag_clr = 0;
    chk("R11 set wins", babble_flag, 1);
    end_pkt(0); clr(3'b001);
    // R10: saturation, 4100 bytes on limit 8
    start(8, 8, 0, 0); bytes(SAT + 5);
    clr(3'b001); chk("R10 cleared", babble_flag, 0);
    bytes(1); chk("R10 still over", babble_flag, 1);
    end_pkt(0); clr(3'b111);
    repeat (3) cyc();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule